// File: doc/BRIEF.md
# Flash Controller Status Register

This block holds the read-only status word of an embedded flash controller. The controller core sends it event pulses: a command was rejected, a program or erase touched a locked region, a verify check failed after programming, and a single or multiple ECC error was seen on either 64-bit half of the 128-bit flash data bus. Each event is kept as a sticky flag, and each flag has its own clear rule. The controller also supplies a busy level, which the block shows as a live ready bit.

Software reads the word through a simple read port: a strobe and an address. A read that hits the register's offset returns the flags as they stood before that read. It also clears the flags whose rule is clear-on-read. A write to the command register clears the command-error and lock-error flags. The start of a programming operation clears the flash-error flag. A registered ready interrupt is raised while the controller is ready and the mode-register enable bit is set.

Top module: `fctl_status_reg`

## Requirements
- R1: After reset, with `busy` low, a read at offset 0x08 returns 0x0000_0001 and `irq_ready` is 0.
- R2: Bit 0 of the read word is the live inverse of `busy`, with no register delay.
- R3: `irq_ready` equals (not `busy`) AND `irq_en` as sampled at the previous clock edge.
- R4: Bit 1 (command error) is set by `evt_cmd_err`. It is cleared by a read at offset 0x08 or by `cmd_wr`.
- R5: Bit 2 (lock error) is set by `evt_lock_err`. It is cleared by a read at offset 0x08 or by `cmd_wr`.
- R6: Bit 3 (flash error) is set by `evt_verify_fail` and cleared only by `prog_start`. Reads and `cmd_wr` leave it unchanged.
- R7: Bits 16 and 17 hold single (corrected) and multiple (uncorrected) ECC errors on the lower half, from `evt_ecc_single[0]` and `evt_ecc_multi[0]`. Bits 18 and 19 hold the same for the upper half, from index 1. All four stay set until a read at offset 0x08.
- R8: When a set event and a clear condition for a flag fall in the same cycle, the flag is 1 afterwards.
- R9: A read at offset 0x08 returns the values from before its own clear. A read at any other address returns 0 and clears nothing.
- R10: Bits 4 to 15 and 20 to 31 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Controller busy level |
| irq_en | input | 1 | Ready-interrupt enable bit from the mode register |
| evt_cmd_err | input | 1 | Pulse: invalid command or bad key written |
| evt_lock_err | input | 1 | Pulse: program/erase hit a locked region |
| evt_verify_fail | input | 1 | Pulse: end-of-programming verify failed |
| prog_start | input | 1 | Pulse: a programming operation starts |
| cmd_wr | input | 1 | Pulse: command register written |
| evt_ecc_single | input | 2 | Single corrected ECC error, index 0 lower half, 1 upper half |
| evt_ecc_multi | input | 2 | Multiple uncorrected ECC errors, same indexing |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address (byte offset) |
| rd_data | output | 32 | Read data, valid in the cycle of the strobe |
| irq_ready | output | 1 | Ready interrupt |

## Verification
The hardest case to reach from the ports is a set event landing in the same cycle as that flag's clear. It is hardest for the flash-error bit, which has a different clear source from its neighbours. Random stimulus drives events, reads, command writes and programming starts at high enough rates that these collisions happen often. A bench model checks every read word against the expected flags. Directed sequences then force a command-error event to coincide with a status read, and show that the flash-error bit survives reads and command writes until a programming start.

// File: rtl/fsr_pkg.sv
// Package: bit positions and flag bundle shared by the status register blocks.
// Assumes a 32-bit status word with two ECC halves.
package fsr_pkg;
    localparam int DATA_W       = 32;
    localparam int N_HALVES     = 2;
    localparam int BIT_READY    = 0;
    localparam int BIT_CMD_ERR  = 1;
    localparam int BIT_LOCK_ERR = 2;
    localparam int BIT_FL_ERR   = 3;
    localparam int BIT_ECC_BASE = 16;   // per half h: single at base+2h, multi at base+2h+1

    typedef struct packed {
        logic                cmd_err;
        logic                lock_err;
        logic                flash_err;
        logic [N_HALVES-1:0] ecc_single;
        logic [N_HALVES-1:0] ecc_multi;
    } fsr_flags_t;
endpackage

// File: rtl/fsr_sticky_flag.sv
// Module: one sticky status bit. Set has priority over clear, so an event in
// the same cycle as a clear is never lost. Assumes set/clr are single-cycle
// qualified strobes from the same clock domain.
module fsr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag state: set wins, else clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);                                               // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);                                    // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> (q == $past(q)));                      // R7
endmodule

// File: rtl/fsr_ecc_bank.sv
// Module: sticky single/multiple ECC flags for each half of the flash data bus.
// Assumes every flag in the bank shares one clear source (status read).
module fsr_ecc_bank #(
    parameter int HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALVES-1:0] single_evt,
    input  logic [HALVES-1:0] multi_evt,
    input  logic              rd_clr,
    output logic [HALVES-1:0] single_q,
    output logic [HALVES-1:0] multi_q
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        fsr_sticky_flag u_single (
            .clk (clk), .rst_n (rst_n),
            .set (single_evt[h]), .clr (rd_clr), .q (single_q[h])
        );
        fsr_sticky_flag u_multi (
            .clk (clk), .rst_n (rst_n),
            .set (multi_evt[h]), .clr (rd_clr), .q (multi_q[h])
        );
    end
endmodule

// File: rtl/fsr_read_mux.sv
// Module: address decode and word assembly for the status read port.
// Assumes the read is combinational in the strobe cycle; unused bits are zero.
module fsr_read_mux
    import fsr_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ready,
    input  fsr_flags_t        flags,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    // Decode: the strobe only counts at this register's offset.
    always_comb rd_hit = rd_en && (rd_addr == REG_OFFSET);

    // Assemble the status word; unused bits stay 0.
    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            rd_data[BIT_READY]    = ready;
            rd_data[BIT_CMD_ERR]  = flags.cmd_err;
            rd_data[BIT_LOCK_ERR] = flags.lock_err;
            rd_data[BIT_FL_ERR]   = flags.flash_err;
            for (int h = 0; h < N_HALVES; h++) begin
                rd_data[BIT_ECC_BASE + 2*h]     = flags.ecc_single[h];
                rd_data[BIT_ECC_BASE + 2*h + 1] = flags.ecc_multi[h];
            end
        end
    end
endmodule

// File: rtl/fctl_status_reg.sv
// Module: flash controller status register top. Gathers event pulses into
// sticky flags with per-flag clear rules, shows the live ready level, and
// drives a registered ready interrupt. Assumes all inputs are synchronous to clk.
module fctl_status_reg
    import fsr_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                irq_en,
    input  logic                evt_cmd_err,
    input  logic                evt_lock_err,
    input  logic                evt_verify_fail,
    input  logic                prog_start,
    input  logic                cmd_wr,
    input  logic [N_HALVES-1:0] evt_ecc_single,
    input  logic [N_HALVES-1:0] evt_ecc_multi,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_ready
);
    fsr_flags_t flags;
    logic       rd_hit;
    logic       ready;
    logic       clr_rd_or_cmd;

    // Live ready level and the shared clear source for bits 1 and 2.
    always_comb begin
        ready         = !busy;
        clr_rd_or_cmd = rd_hit || cmd_wr;
    end

    fsr_sticky_flag u_cmd_err (
        .clk (clk), .rst_n (rst_n),
        .set (evt_cmd_err), .clr (clr_rd_or_cmd), .q (flags.cmd_err)
    );
    fsr_sticky_flag u_lock_err (
        .clk (clk), .rst_n (rst_n),
        .set (evt_lock_err), .clr (clr_rd_or_cmd), .q (flags.lock_err)
    );
    fsr_sticky_flag u_flash_err (
        .clk (clk), .rst_n (rst_n),
        .set (evt_verify_fail), .clr (prog_start), .q (flags.flash_err)
    );

    fsr_ecc_bank #(.HALVES(N_HALVES)) u_ecc (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_evt (evt_ecc_single),
        .multi_evt  (evt_ecc_multi),
        .rd_clr     (rd_hit),
        .single_q   (flags.ecc_single),
        .multi_q    (flags.ecc_multi)
    );

    fsr_read_mux #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_rd (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ready   (ready),
        .flags   (flags),
        .rd_hit  (rd_hit),
        .rd_data (rd_data)
    );

    // Ready interrupt: registered AND of ready level and mode enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_ready <= 1'b0;
        else        irq_ready <= ready && irq_en;
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_ready == $past(!busy && irq_en)));                    // R3
    AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en && rd_addr == REG_OFFSET || cmd_wr) && !evt_cmd_err)
            |=> !flags.cmd_err);                                             // R4
    AST_LOCK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en && rd_addr == REG_OFFSET || cmd_wr) && !evt_lock_err)
            |=> !flags.lock_err);                                            // R5
    AST_FLERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.flash_err && !prog_start) |=> flags.flash_err);               // R6
    AST_MISS_CLEARS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && rd_addr == REG_OFFSET) && !cmd_wr && flags.cmd_err)
            |=> flags.cmd_err);                                              // R9
    AST_READY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_OFFSET) |-> (rd_data[BIT_READY] == !busy)); // R2
endmodule

// File: tb/fctl_status_reg_tb.sv
module fctl_status_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFS = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0, irq_en = 1'b0;
    logic        evt_cmd_err = 1'b0, evt_lock_err = 1'b0, evt_verify_fail = 1'b0;
    logic        prog_start = 1'b0, cmd_wr = 1'b0;
    logic [1:0]  evt_ecc_single = '0, evt_ecc_multi = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_ready;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic m_cmd = 0, m_lock = 0, m_fl = 0, m_irq = 0;
    logic [1:0] m_es = '0, m_em = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fctl_status_reg u_dut (
        .clk (clk), .rst_n (rst_n), .busy (busy), .irq_en (irq_en),
        .evt_cmd_err (evt_cmd_err), .evt_lock_err (evt_lock_err),
        .evt_verify_fail (evt_verify_fail), .prog_start (prog_start),
        .cmd_wr (cmd_wr), .evt_ecc_single (evt_ecc_single),
        .evt_ecc_multi (evt_ecc_multi), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .irq_ready (irq_ready)
    );

    function automatic logic hit();
        return rd_en && (rd_addr == OFS);
    endfunction

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        if (hit()) begin
            w[0] = !busy; w[1] = m_cmd; w[2] = m_lock; w[3] = m_fl;
            w[16] = m_es[0]; w[17] = m_em[0]; w[18] = m_es[1]; w[19] = m_em[1];
        end
        return w;
    endfunction

    function automatic string tag_of(logic [31:0] d);
        if (!hit())      return "R9";
        if (d[0])        return "R2";
        if (d[1])        return "R4";
        if (d[2])        return "R5";
        if (d[3])        return "R6";
        if (|d[19:16])   return "R7";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check outputs mid-cycle, clock once, update the model from the driven inputs.
    task automatic step();
        #1;
        chk(tag_of(rd_data ^ exp_word()), rd_data, exp_word());
        chk("R3 irq_ready", {31'd0, irq_ready}, {31'd0, m_irq});
        @(posedge clk);
        m_irq = !busy && irq_en;
        if (evt_cmd_err) m_cmd = 1; else if (hit() || cmd_wr) m_cmd = 0;
        if (evt_lock_err) m_lock = 1; else if (hit() || cmd_wr) m_lock = 0;
        if (evt_verify_fail) m_fl = 1; else if (prog_start) m_fl = 0;
        for (int h = 0; h < 2; h++) begin
            if (evt_ecc_single[h]) m_es[h] = 1; else if (hit()) m_es[h] = 0;
            if (evt_ecc_multi[h])  m_em[h] = 1; else if (hit()) m_em[h] = 0;
        end
        @(negedge clk);
        evt_cmd_err = 0; evt_lock_err = 0; evt_verify_fail = 0;
        prog_start = 0; cmd_wr = 0; evt_ecc_single = '0; evt_ecc_multi = '0;
        rd_en = 0; rd_addr = OFS;
    endtask

    task automatic read_now(string tag, logic [31:0] exp);
        rd_en = 1; rd_addr = OFS;
        #1; chk(tag, rd_data, exp);
        step();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        read_now("R1 reset word", 32'h0000_0001);
        // R10 / R9: miss address reads 0 and clears nothing
        evt_cmd_err = 1; step();
        rd_en = 1; rd_addr = 8'h0C; #1; chk("R9 miss read", rd_data, 32'h0); step();
        read_now("R9 pre-clear value", 32'h0000_0003);
        read_now("R4 cleared by read", 32'h0000_0001);
        // R8: event colliding with read clear
        evt_cmd_err = 1; rd_en = 1; rd_addr = OFS; step();
        read_now("R8 collision kept", 32'h0000_0003);
        evt_lock_err = 1; cmd_wr = 1; step();
        read_now("R8 lock vs cmd_wr", 32'h0000_0005);
        // R6: flash error survives reads and cmd writes
        evt_verify_fail = 1; step();
        cmd_wr = 1; step();
        read_now("R6 kept after cmd_wr", 32'h0000_0009);
        read_now("R6 kept after read", 32'h0000_0009);
        prog_start = 1; evt_verify_fail = 1; step();
        read_now("R8 flerr collision", 32'h0000_0009);
        prog_start = 1; step();
        read_now("R6 cleared by prog_start", 32'h0000_0001);
        // R7: ECC bit mapping
        evt_ecc_single = 2'b01; step();
        evt_ecc_multi = 2'b10; step();
        read_now("R7 ecc map", 32'h0008_0001 | 32'h0001_0000);
        // R2/R3: ready and interrupt
        busy = 1; irq_en = 1; step();
        read_now("R2 busy", 32'h0);
        busy = 0; step();
        step();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            busy            = ($urandom_range(3) == 0);
            irq_en          = ($urandom_range(1) == 0);
            evt_cmd_err     = ($urandom_range(5) == 0);
            evt_lock_err    = ($urandom_range(5) == 0);
            evt_verify_fail = ($urandom_range(6) == 0);
            prog_start      = ($urandom_range(6) == 0);
            cmd_wr          = ($urandom_range(5) == 0);
            evt_ecc_single  = 2'($urandom_range(3)) & {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
            evt_ecc_multi   = 2'($urandom_range(3)) & {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
            rd_en           = ($urandom_range(2) == 0);
            rd_addr         = ($urandom_range(4) == 0) ? 8'($urandom_range(255)) : OFS;
            step();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule